// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This unit watches a processor's instruction pointer, its data accesses and its I/O port accesses against four programmable address slots. One packed control word holds each slot's settings: two enable bits, a two-bit kind and a two-bit span code. A slot of the execute kind fires on an exact instruction-pointer match. A data slot fires when the accessed byte range overlaps the slot's byte range, and some data slots react to writes only. A port slot fires on overlap with the accessed port range.

All matching is combinational from the current inputs. The result is registered and appears for one cycle after the strobe that caused it. It consists of a hit vector, which is the value the debug status low bits must take, a status-update strobe, a trap request and the address the trap must report. Port hits take precedence over instruction and data hits in the same cycle and report the address of the following instruction.

A disabled slot that matches still contributes its bit to the hit vector, but only when an enabled slot matches in the same cycle. A disabled match on its own leaves every output quiet.

Top module: `dbg_bp_match`

## Requirements
- R1: Slot i counts as enabled when control bit 2*i or control bit 2*i+1 is set. Either bit alone is enough.
- R2: Slot i takes its kind from control bits [17+4*i:16+4*i] and its span code from bits [19+4*i:18+4*i]. Kind 0 is execute, kind 1 is data write, kind 2 is I/O port and kind 3 is data read-or-write.
- R3: Span code 0 covers 1 byte, code 1 covers 2 bytes, code 3 covers 4 bytes and code 2 covers 8 bytes, starting at the slot address.
- R4: An execute slot matches a cycle with ip_valid_i high when its address equals ip_i exactly.
- R5: A data-write slot matches only accesses with dacc_write_i high, and a read-or-write slot matches any access. A data match needs the range [dacc_addr_i, dacc_addr_i+dacc_size_i-1] to overlap the slot range. A size of 0 never matches.
- R6: An I/O slot matches only while enabled, when [io_port_i, io_port_i+io_size_i-1] overlaps the slot range. The port is zero-extended to the address width, and a size of 0 never matches.
- R7: Suppose no I/O slot matches and at least one enabled slot has an execute or data match. Then trap_o and stat_upd_o are 1, hit_o has a bit set for every slot with an execute or data match, enabled or not, and trap_ip_o equals ip_i.
- R8: When no enabled slot matches, hit_o is 0 and trap_o, stat_upd_o and trap_ip_o stay 0, even if a disabled slot matches.
- R9: When any I/O slot matches, hit_o holds exactly the I/O matches, trap_o and stat_upd_o are 1, and trap_ip_o equals io_next_ip_i. This overrides any execute or data result in the same cycle.
- R10: Outputs appear one clock after the strobe cycle and last one cycle. A cycle with no strobe yields all-zero outputs on the next clock, and reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| slot_addr_i | input | 4*32 | Slot addresses, slot i at bits [32*i+31:32*i] |
| ctrl_i | input | 32 | Packed per-slot enables, kinds and span codes |
| ip_valid_i | input | 1 | Instruction pointer check strobe |
| ip_i | input | 32 | Current instruction pointer |
| dacc_valid_i | input | 1 | Data access strobe |
| dacc_addr_i | input | 32 | Data access start address |
| dacc_size_i | input | 4 | Data access size in bytes |
| dacc_write_i | input | 1 | Data access is a write |
| io_valid_i | input | 1 | Port access strobe |
| io_port_i | input | 16 | Port access start number |
| io_size_i | input | 4 | Port access size in bytes |
| io_next_ip_i | input | 32 | Address of the instruction after the port access |
| hit_o | output | 4 | New status low bits, one per slot |
| trap_o | output | 1 | Debug trap request pulse |
| stat_upd_o | output | 1 | Status low bits must be rewritten with hit_o |
| trap_ip_o | output | 32 | Address the trap reports |

## Verification
The assertions assume that the strobes stay low while reset is asserted. They also assume that the control word, slot addresses and access fields are steady during the strobe cycle, so the registered result can be traced to the previous cycle's inputs. Access sizes are taken to be at most 8 bytes, and the addresses are taken to be far enough from the top of the address space that a range does not wrap.

The stimulus holds every strobe at 0 during reset and uses sizes 1, 2, 4 and 8. It places every slot near a base address well away from zero and from the top, and sweeps offsets of up to nine bytes on each side of it. All four slots share that base, so disabled and differently-kinded neighbours always overlap the slot under test.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;

    typedef enum logic [1:0] {
        KIND_EXEC = 2'd0,
        KIND_DWR  = 2'd1,
        KIND_IO   = 2'd2,
        KIND_DRW  = 2'd3
    } bp_kind_e;

    typedef struct packed {
        logic     en;
        bp_kind_e kind;
        logic [3:0] span;
    } slot_cfg_t;

    // Span code to byte count: the code 2 stands for the widest span.
    function automatic logic [3:0] span_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            2'd2:    return 4'd8;
            default: return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/dbg_bp_slot_dec.sv
module dbg_bp_slot_dec
    import dbg_bp_pkg::*;
(
    input  logic [1:0] en_bits_i,
    input  logic [1:0] kind_bits_i,
    input  logic [1:0] span_bits_i,
    output slot_cfg_t  cfg_o
);

    always_comb begin
        cfg_o.en   = |en_bits_i;                 // R1: local or global
        cfg_o.kind = bp_kind_e'(kind_bits_i);    // R2
        cfg_o.span = span_bytes(span_bits_i);    // R3
    end

endmodule

// File: rtl/dbg_bp_range_ovl.sv
module dbg_bp_range_ovl #(
    parameter int AW = 32,
    parameter int SW = 4
) (
    input  logic [AW-1:0] a_base_i,
    input  logic [SW-1:0] a_len_i,
    input  logic [AW-1:0] b_base_i,
    input  logic [SW-1:0] b_len_i,
    output logic          ovl_o
);

    localparam int XW = AW + 1;

    logic [XW-1:0] a_first, a_last, b_first, b_last;

    always_comb begin
        a_first = {1'b0, a_base_i};
        b_first = {1'b0, b_base_i};
        a_last  = a_first + XW'(a_len_i) - XW'(1);
        b_last  = b_first + XW'(b_len_i) - XW'(1);
        ovl_o   = (a_len_i != '0) && (b_len_i != '0)
                  && (a_last >= b_first) && (a_first <= b_last);
    end

endmodule

// File: rtl/dbg_bp_slot_cmp.sv
module dbg_bp_slot_cmp
    import dbg_bp_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 16,
    parameter int SW = 4
) (
    input  slot_cfg_t     cfg_i,
    input  logic [AW-1:0] slot_addr_i,
    input  logic          ip_valid_i,
    input  logic [AW-1:0] ip_i,
    input  logic          dacc_valid_i,
    input  logic [AW-1:0] dacc_addr_i,
    input  logic [SW-1:0] dacc_size_i,
    input  logic          dacc_write_i,
    input  logic          io_valid_i,
    input  logic [PW-1:0] io_port_i,
    input  logic [SW-1:0] io_size_i,
    output logic          id_hit_o,
    output logic          io_hit_o
);

    logic [SW-1:0] span_w;
    logic          data_ovl, io_ovl;
    logic          exec_m, data_m;

    assign span_w = SW'(cfg_i.span);

    dbg_bp_range_ovl #(.AW(AW), .SW(SW)) u_data_ovl (
        .a_base_i (dacc_addr_i),
        .a_len_i  (dacc_size_i),
        .b_base_i (slot_addr_i),
        .b_len_i  (span_w),
        .ovl_o    (data_ovl)
    );

    dbg_bp_range_ovl #(.AW(AW), .SW(SW)) u_io_ovl (
        .a_base_i (AW'(io_port_i)),
        .a_len_i  (io_size_i),
        .b_base_i (slot_addr_i),
        .b_len_i  (span_w),
        .ovl_o    (io_ovl)
    );

    always_comb begin
        exec_m   = ip_valid_i && (cfg_i.kind == KIND_EXEC) && (ip_i == slot_addr_i);
        data_m   = dacc_valid_i && data_ovl
                   && ((cfg_i.kind == KIND_DRW) || ((cfg_i.kind == KIND_DWR) && dacc_write_i));
        id_hit_o = exec_m || data_m;                     // R4, R5: enable not required
        io_hit_o = io_valid_i && cfg_i.en && (cfg_i.kind == KIND_IO) && io_ovl;  // R6
    end

endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
    import dbg_bp_pkg::*;
#(
    parameter int N         = 4,
    parameter int AW        = 32,
    parameter int PW        = 16,
    parameter int SW        = 4,
    parameter int CW        = 32,
    parameter int KIND_BASE = 16,
    parameter int SPAN_BASE = 18,
    parameter int STRIDE    = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N*AW-1:0] slot_addr_i,
    input  logic [CW-1:0]   ctrl_i,
    input  logic            ip_valid_i,
    input  logic [AW-1:0]   ip_i,
    input  logic            dacc_valid_i,
    input  logic [AW-1:0]   dacc_addr_i,
    input  logic [SW-1:0]   dacc_size_i,
    input  logic            dacc_write_i,
    input  logic            io_valid_i,
    input  logic [PW-1:0]   io_port_i,
    input  logic [SW-1:0]   io_size_i,
    input  logic [AW-1:0]   io_next_ip_i,
    output logic [N-1:0]    hit_o,
    output logic            trap_o,
    output logic            stat_upd_o,
    output logic [AW-1:0]   trap_ip_o
);

    localparam int EN_TOP = 2 * N;

    typedef struct packed {
        logic [N-1:0]  hit;
        logic          trap;
        logic          upd;
        logic [AW-1:0] tip;
    } res_t;

    res_t         res_d, res_q;
    logic [N-1:0] en_vec, id_hit, io_hit;
    logic         unused_ctrl;

    assign unused_ctrl = ^ctrl_i[KIND_BASE-1:EN_TOP];

    for (genvar g = 0; g < N; g++) begin : g_slot
        slot_cfg_t cfg;

        dbg_bp_slot_dec u_dec (
            .en_bits_i   (ctrl_i[2*g +: 2]),
            .kind_bits_i (ctrl_i[KIND_BASE + STRIDE*g +: 2]),
            .span_bits_i (ctrl_i[SPAN_BASE + STRIDE*g +: 2]),
            .cfg_o       (cfg)
        );

        dbg_bp_slot_cmp #(.AW(AW), .PW(PW), .SW(SW)) u_cmp (
            .cfg_i        (cfg),
            .slot_addr_i  (slot_addr_i[AW*g +: AW]),
            .ip_valid_i   (ip_valid_i),
            .ip_i         (ip_i),
            .dacc_valid_i (dacc_valid_i),
            .dacc_addr_i  (dacc_addr_i),
            .dacc_size_i  (dacc_size_i),
            .dacc_write_i (dacc_write_i),
            .io_valid_i   (io_valid_i),
            .io_port_i    (io_port_i),
            .io_size_i    (io_size_i),
            .id_hit_o     (id_hit[g]),
            .io_hit_o     (io_hit[g])
        );

        assign en_vec[g] = cfg.en;
    end

    // Next result: port hits win, then enabled instruction/data hits.
    always_comb begin
        res_d = '0;
        if (|io_hit) begin                          // R9
            res_d.hit  = io_hit;
            res_d.trap = 1'b1;
            res_d.upd  = 1'b1;
            res_d.tip  = io_next_ip_i;
        end else if (|(id_hit & en_vec)) begin      // R7
            res_d.hit  = id_hit;
            res_d.trap = 1'b1;
            res_d.upd  = 1'b1;
            res_d.tip  = ip_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) res_q <= '0;                   // R10
        else         res_q <= res_d;
    end

    assign hit_o      = res_q.hit;
    assign trap_o     = res_q.trap;
    assign stat_upd_o = res_q.upd;
    assign trap_ip_o  = res_q.tip;

    a_r7_trap_with_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> stat_upd_o);

    a_r8_quiet_without_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_upd_o |-> (hit_o == '0) && !trap_o && (trap_ip_o == '0));

    a_r7_enabled_slot_behind_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> ((hit_o & $past(en_vec)) != '0));

    a_r10_trap_follows_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> $past(ip_valid_i || dacc_valid_i || io_valid_i));

    a_r9_port_trap_reports_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_o && $past(io_hit != '0)) |-> (trap_ip_o == $past(io_next_ip_i)) && (hit_o == $past(io_hit)));

endmodule

// File: tb/dbg_bp_match_bench.sv
module dbg_bp_match_bench;

    localparam int N  = 4;
    localparam int AW = 32;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N*AW-1:0] slot_addr = '0;
    logic [31:0]   ctrl = '0;
    logic          ip_valid = 1'b0;
    logic [31:0]   ip = '0;
    logic          dacc_valid = 1'b0;
    logic [31:0]   dacc_addr = '0;
    logic [3:0]    dacc_size = '0;
    logic          dacc_write = 1'b0;
    logic          io_valid = 1'b0;
    logic [15:0]   io_port = '0;
    logic [3:0]    io_size = '0;
    logic [31:0]   io_next_ip = '0;
    logic [3:0]    hit;
    logic          trap, upd;
    logic [31:0]   trap_ip;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dbg_bp_match u_dbg_bp_match (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .slot_addr_i  (slot_addr),
        .ctrl_i       (ctrl),
        .ip_valid_i   (ip_valid),
        .ip_i         (ip),
        .dacc_valid_i (dacc_valid),
        .dacc_addr_i  (dacc_addr),
        .dacc_size_i  (dacc_size),
        .dacc_write_i (dacc_write),
        .io_valid_i   (io_valid),
        .io_port_i    (io_port),
        .io_size_i    (io_size),
        .io_next_ip_i (io_next_ip),
        .hit_o        (hit),
        .trap_o       (trap),
        .stat_upd_o   (upd),
        .trap_ip_o    (trap_ip)
    );

    function automatic bit overlaps(longint p, longint ps, longint q, longint ql);
        return (ps > 0) && (ql > 0) && (p + ps - 1 >= q) && (p <= q + ql - 1);
    endfunction

    // Reference result computed from the requirement text.
    task automatic predict(output logic [3:0] eh, output logic et, output logic [31:0] eip);
        logic [3:0] idm, iom, env;
        idm = '0; iom = '0; env = '0;
        for (int i = 0; i < N; i++) begin
            logic [1:0] ty, lc;
            longint ln, a;
            env[i] = ctrl[2*i] | ctrl[2*i+1];
            ty = ctrl[16+4*i +: 2];
            lc = ctrl[18+4*i +: 2];
            ln = (lc == 2'd2) ? 8 : longint'(lc) + 1;
            a  = longint'(slot_addr[32*i +: 32]);
            if (ip_valid && ty == 2'd0 && longint'(ip) == a) idm[i] = 1'b1;
            if (dacc_valid && (ty == 2'd3 || (ty == 2'd1 && dacc_write))
                && overlaps(longint'(dacc_addr), longint'(dacc_size), a, ln)) idm[i] = 1'b1;
            if (io_valid && env[i] && ty == 2'd2
                && overlaps(longint'(io_port), longint'(io_size), a, ln)) iom[i] = 1'b1;
        end
        if (iom != '0) begin
            eh = iom; et = 1'b1; eip = io_next_ip;
        end else if ((idm & env) != '0) begin
            eh = idm; et = 1'b1; eip = ip;
        end else begin
            eh = '0; et = 1'b0; eip = '0;
        end
    endtask

    task automatic compare(string tag, logic [3:0] eh, logic et, logic [31:0] eip);
        checks++;
        if (hit !== eh || trap !== et || upd !== et || trap_ip !== eip) begin
            fails++;
            $display("FAIL %s: hit=%h/%h trap=%b/%b upd=%b/%b ip=%h/%h",
                     tag, hit, eh, trap, et, upd, et, trap_ip, eip);
        end
    endtask

    // Called just after a falling edge with inputs set.
    task automatic run_vec(string tag);
        logic [3:0] eh; logic et; logic [31:0] eip;
        predict(eh, et, eip);
        @(posedge clk); @(negedge clk);
        compare(tag, eh, et, eip);
        ip_valid = 1'b0; dacc_valid = 1'b0; io_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        compare("R10 idle after strobe", 4'h0, 1'b0, 32'h0);
    endtask

    task automatic setup(int s, int cfg);
        ctrl = '0;
        for (int j = 0; j < N; j++) begin
            slot_addr[32*j +: 32] = BASE;
            if (j == s) begin
                ctrl[2*j +: 2]    = 2'(cfg);
                ctrl[16+4*j +: 2] = 2'(cfg >> 2);
                ctrl[18+4*j +: 2] = 2'(cfg >> 4);
            end else if (j == (s + 1) % N) begin
                ctrl[2*j] = 1'b1;                    // enabled execute, 1 byte
            end else if (j == (s + 2) % N) begin
                ctrl[16+4*j +: 2] = 2'd3;            // disabled read/write, 4 bytes
                ctrl[18+4*j +: 2] = 2'd3;
            end else begin
                ctrl[2*j+1]       = 1'b1;            // global-enabled port, 2 bytes
                ctrl[16+4*j +: 2] = 2'd2;
                ctrl[18+4*j +: 2] = 2'd1;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R10 reset state", 4'h0, 1'b0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R10 after reset release", 4'h0, 1'b0, 32'h0);

        for (int s = 0; s < N; s++) begin
            for (int cfg = 0; cfg < 64; cfg++) begin
                setup(s, cfg);
                for (int off = -2; off <= 2; off++) begin
                    ip = BASE + 32'(off); ip_valid = 1'b1;
                    run_vec("R1 R2 R4 R7 R8 execute sweep");
                end
                for (int k = 0; k < 4; k++) begin
                    if (s != 0 && (k == 1 || k == 2)) continue;
                    for (int w = 0; w < 2; w++) begin
                        for (int off = -9; off <= 9; off++) begin
                            dacc_addr = BASE + 32'(off); dacc_size = 4'(1 << k);
                            dacc_write = w[0]; dacc_valid = 1'b1; ip = 32'h0000_7700 + 32'(off);
                            run_vec("R2 R3 R5 R7 R8 data sweep");
                        end
                    end
                    for (int off = -9; off <= 9; off++) begin
                        io_port = 16'(BASE + 32'(off)); io_size = 4'(1 << k);
                        io_next_ip = 32'h0000_9000 + 32'(cfg); io_valid = 1'b1;
                        run_vec("R1 R3 R6 R9 port sweep");
                    end
                end
            end
        end

        // Simultaneous strobes: port result must override instruction/data.
        for (int cfg = 0; cfg < 64; cfg++) begin
            setup(0, cfg);
            for (int m = 1; m < 8; m++) begin
                ip = BASE; ip_valid = m[0];
                dacc_addr = BASE + 32'd1; dacc_size = 4'd2; dacc_write = 1'b1; dacc_valid = m[1];
                io_port = 16'(BASE); io_size = 4'd1; io_next_ip = 32'h0000_A000 + 32'(m);
                io_valid = m[2];
                run_vec("R9 R7 simultaneous strobes");
            end
        end

        // Size zero never matches.
        setup(0, 6'b11_11_01);
        dacc_addr = BASE; dacc_size = 4'd0; dacc_write = 1'b1; dacc_valid = 1'b1;
        run_vec("R5 zero-size data access");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R10 watchdog: done=0/1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule